// File: doc/BRIEF.md
# Power Stage Fault and Sleep Supervisor

This block decides, every clock cycle, whether the bridge drivers of a stepper power stage may switch. It watches two digitized sensor readings, junction temperature and logic supply voltage, each arriving as an unsigned code with a one-cycle valid strobe. It also watches a gate-supply-good flag and an active-low sleep request. Each reading is compared against a trip threshold with hysteresis, and the result is held in a flag until a later valid reading moves it across the opposite threshold.

There are two kinds of response. Over-temperature or a missing gate supply only blocks the drivers; the step sequencer keeps running and accepts steps. Logic undervoltage is more severe: it blocks the drivers, refuses steps and asks the sequencer to return to its home position. Undervoltage is assumed at reset. Sleep behaves like undervoltage while it is held. When sleep is released, a wake-up lockout of a programmable number of cycles keeps steps refused so the gate drive can settle. The default is 1 ms at 100 MHz. If undervoltage appears during that lockout, the count starts over once the supply is good again.

Top module: `drv_supervisor`

## Requirements
- R1: Out of reset and until a valid supply reading at or above `UV_RISE` arrives, `drive_en` is 0, `home_req` is 1 and `step_ok` is 0.
- R2: The supply flag clears on a valid reading with code >= `UV_RISE` and sets on a valid reading with code < `UV_RISE - UV_HYST`. A reading between the two leaves the flag unchanged. The new value shows at the outputs one clock edge after the strobed reading.
- R3: While the supply flag is set, `home_req` is 1 and both `drive_en` and `step_ok` are 0.
- R4: The thermal flag sets on a valid reading with code >= `TEMP_TRIP` and clears on a valid reading with code <= `TEMP_TRIP - TEMP_HYST`. A reading between the two holds the flag. It takes effect one edge after the reading.
- R5: A set thermal flag or `gate_ok` = 0 forces `drive_en` to 0 and nothing else. `home_req` stays 0 and `step_ok` stays 1. `gate_ok` acts in the same cycle.
- R6: `drive_en` is 1 exactly when sleep is released, `gate_ok` is 1 and neither flag is set.
- R7: While `sleep_n` is 0, in the same cycle, `drive_en` is 0, `home_req` is 1 and `step_ok` is 0.
- R8: After `sleep_n` returns to 1 with the supply good, `step_ok` stays 0 for `WAKE_CYCLES - 1` rising edges and becomes 1 after the `WAKE_CYCLES`-th.
- R9: If the supply flag sets during the wake-up lockout, the count restarts. `step_ok` rises `WAKE_CYCLES` edges after the edge that clears the flag.
- R10: Codes presented without their valid strobe change neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_code | input | TEMP_W | Junction temperature code |
| temp_valid | input | 1 | Strobe marking `temp_code` as a fresh reading |
| vdd_code | input | VDD_W | Logic supply voltage code |
| vdd_valid | input | 1 | Strobe marking `vdd_code` as a fresh reading |
| gate_ok | input | 1 | Gate-drive supply is adequate |
| sleep_n | input | 1 | Active-low sleep request |
| drive_en | output | 1 | Bridge drivers may switch |
| home_req | output | 1 | Sequencer must go to and hold its home state |
| step_ok | output | 1 | Step commands may be accepted |

## Verification
Each sensor reading updates its flag on the first rising edge that samples the strobe. The bench therefore drives a reading on a falling edge and checks the outputs on the very next falling edge. The outputs that depend on `sleep_n` and `gate_ok` are combinational, so they are checked one time unit after those inputs change, with no edge in between. The wake-up result is checked on every falling edge after release. The bench expects `step_ok` low on the first `WAKE_CYCLES - 1` of these and high from the `WAKE_CYCLES`-th on, and repeats this count from the edge that clears an undervoltage injected during the wait.

// File: rtl/drv_supervisor.sv
module drv_supervisor #(
  parameter int TEMP_W      = 10,
  parameter int VDD_W       = 10,
  parameter int TEMP_TRIP   = 660,
  parameter int TEMP_HYST   = 60,
  parameter int UV_RISE     = 553,
  parameter int UV_HYST     = 20,
  parameter int WAKE_CYCLES = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              temp_valid,
  input  logic [VDD_W-1:0]  vdd_code,
  input  logic              vdd_valid,
  input  logic              gate_ok,
  input  logic              sleep_n,
  output logic              drive_en,
  output logic              home_req,
  output logic              step_ok
);
  localparam logic [TEMP_W-1:0] TRIP_C = TEMP_W'(TEMP_TRIP);
  localparam logic [TEMP_W-1:0] COOL_C = TEMP_W'(TEMP_TRIP - TEMP_HYST);
  localparam logic [VDD_W-1:0]  RISE_C = VDD_W'(UV_RISE);
  localparam logic [VDD_W-1:0]  FALL_C = VDD_W'(UV_RISE - UV_HYST);
  localparam int CW = (WAKE_CYCLES > 2) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST_C = CW'(WAKE_CYCLES - 1);

  logic          hot;
  logic          uv;
  logic          pending;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hot <= 1'b0;
    else if (temp_valid) begin
      if (temp_code >= TRIP_C)      hot <= 1'b1;
      else if (temp_code <= COOL_C) hot <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uv <= 1'b1;
    else if (vdd_valid) begin
      if (vdd_code >= RISE_C)     uv <= 1'b0;
      else if (vdd_code < FALL_C) uv <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (!sleep_n) begin
      pending <= 1'b1;
      cnt     <= '0;
    end else if (uv) begin
      cnt <= '0;
    end else if (pending) begin
      if (cnt == LAST_C) begin
        pending <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign drive_en = sleep_n & gate_ok & ~hot & ~uv;
  assign home_req = uv | ~sleep_n;
  assign step_ok  = sleep_n & ~uv & ~pending;
endmodule

// File: rtl/drv_supervisor_chk.sv
module drv_supervisor_chk #(
  parameter int TEMP_W    = 10,
  parameter int VDD_W     = 10,
  parameter int TEMP_TRIP = 660,
  parameter int UV_RISE   = 553,
  parameter int UV_HYST   = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TEMP_W-1:0] temp_code,
  input logic              temp_valid,
  input logic [VDD_W-1:0]  vdd_code,
  input logic              vdd_valid,
  input logic              gate_ok,
  input logic              sleep_n,
  input logic              drive_en,
  input logic              home_req,
  input logic              step_ok,
  input logic              hot,
  input logic              uv
);
  p_sleep_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |-> (!drive_en && home_req && !step_ok));

  p_home_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    home_req |-> (!drive_en && !step_ok));

  p_gate_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_ok |-> !drive_en);

  p_hot_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_valid && temp_code >= TEMP_W'(TEMP_TRIP)) |=> !drive_en);

  p_uv_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vdd_valid && vdd_code < VDD_W'(UV_RISE - UV_HYST)) |=> (home_req && !step_ok));

  p_wake_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_n) |=> !step_ok);

  p_temp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_valid |=> $stable(hot));

  p_vdd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !vdd_valid |=> $stable(uv));
endmodule

bind drv_supervisor drv_supervisor_chk #(
  .TEMP_W(TEMP_W), .VDD_W(VDD_W), .TEMP_TRIP(TEMP_TRIP),
  .UV_RISE(UV_RISE), .UV_HYST(UV_HYST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .temp_valid(temp_valid),
  .vdd_code(vdd_code), .vdd_valid(vdd_valid), .gate_ok(gate_ok),
  .sleep_n(sleep_n), .drive_en(drive_en), .home_req(home_req),
  .step_ok(step_ok), .hot(hot), .uv(uv)
);

// File: tb/drv_supervisor_bench.sv
module drv_supervisor_bench;
  localparam int PERIOD = 10;
  localparam int TW = 8, VW = 8;
  localparam int TRIP = 200, THYS = 15, RISE = 135, UHYS = 5, WAKE = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TW-1:0] temp_code = '0;
  logic [VW-1:0] vdd_code = '0;
  logic temp_valid = 1'b0, vdd_valid = 1'b0, gate_ok = 1'b1, sleep_n = 1'b1;
  logic drive_en, home_req, step_ok;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  drv_supervisor #(.TEMP_W(TW), .VDD_W(VW), .TEMP_TRIP(TRIP), .TEMP_HYST(THYS),
    .UV_RISE(RISE), .UV_HYST(UHYS), .WAKE_CYCLES(WAKE)) u_drv_supervisor (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .temp_valid(temp_valid),
    .vdd_code(vdd_code), .vdd_valid(vdd_valid), .gate_ok(gate_ok),
    .sleep_n(sleep_n), .drive_en(drive_en), .home_req(home_req), .step_ok(step_ok));

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic vdd_read(int c);
    vdd_code = VW'(c); vdd_valid = 1'b1;
    @(negedge clk); vdd_valid = 1'b0;
  endtask

  task automatic temp_read(int c);
    temp_code = TW'(c); temp_valid = 1'b1;
    @(negedge clk); temp_valid = 1'b0;
  endtask

  initial begin
    #(PERIOD*200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 drive in reset", drive_en, 1'b0);
    chk("R1 home in reset", home_req, 1'b1);
    chk("R1 step in reset", step_ok, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 home before reading", home_req, 1'b1);
    chk("R3 step blocked in uv", step_ok, 1'b0);
    // R10: good code without strobe ignored
    vdd_code = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R10 unstrobed vdd ignored", home_req, 1'b1);

    // R2 exhaustive sweep from both flag states
    for (int c = 0; c < 256; c++) begin
      vdd_read(255);
      vdd_read(c);
      chk("R2 from clear", home_req, logic'(c < RISE - UHYS));
      chk("R3 drive follows uv", drive_en, logic'(c >= RISE - UHYS));
      vdd_read(0);
      vdd_read(c);
      chk("R2 from set", home_req, logic'(c < RISE));
    end
    vdd_read(255);
    chk("R6 all good", drive_en, 1'b1);

    // R4 exhaustive sweep, R5 fault-only response
    for (int c = 0; c < 256; c++) begin
      temp_read(0);
      temp_read(c);
      chk("R4 from cool", drive_en, logic'(c < TRIP));
      chk("R5 hot keeps home low", home_req, 1'b0);
      chk("R5 hot keeps steps", step_ok, 1'b1);
      temp_read(255);
      temp_read(c);
      chk("R4 from hot", drive_en, logic'(c <= TRIP - THYS));
    end
    temp_read(0);
    temp_code = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R10 unstrobed temp ignored", drive_en, 1'b1);

    gate_ok = 1'b0; #1;
    chk("R5 gate low drive", drive_en, 1'b0);
    chk("R5 gate low home", home_req, 1'b0);
    chk("R5 gate low step", step_ok, 1'b1);
    @(negedge clk); gate_ok = 1'b1; #1;
    chk("R6 gate restored", drive_en, 1'b1);

    // R7 / R8 sleep and wake lockout
    @(negedge clk); sleep_n = 1'b0; #1;
    chk("R7 sleep drive", drive_en, 1'b0);
    chk("R7 sleep home", home_req, 1'b1);
    chk("R7 sleep step", step_ok, 1'b0);
    repeat (4) @(negedge clk);
    sleep_n = 1'b1;
    for (int k = 1; k <= WAKE + 2; k++) begin
      @(negedge clk);
      chk("R8 wake count", step_ok, logic'(k >= WAKE));
      chk("R8 drive after wake", drive_en, 1'b1);
    end

    // R9 uv during wait restarts count
    sleep_n = 1'b0;
    repeat (2) @(negedge clk);
    sleep_n = 1'b1;
    repeat (5) @(negedge clk);
    vdd_read(0);
    repeat (6) @(negedge clk);
    chk("R9 uv during wait", step_ok, 1'b0);
    vdd_read(255);
    for (int k = 1; k <= WAKE + 2; k++) begin
      @(negedge clk);
      chk("R9 restarted count", step_ok, logic'(k >= WAKE));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule